// File: doc/BRIEF.md
# Integer Execute ALU with Set-Compare

This block is the integer execute stage of a small load/store RISC pipeline. Each cycle it takes a first operand, a second operand and an operation code. The second operand is either a register value or a 16-bit immediate that the block sign-extends itself. From these it forms one 32-bit result and a signed-overflow flag.

The functions are:
- add and subtract, in trapping and non-trapping forms;
- bitwise AND, OR and XOR;
- three barrel shifts;
- placement of an immediate in the upper half of the word;
- six signed set-on-condition compares;
- the base-plus-offset sum used as a memory effective address.

The arithmetic is combinational. Result and flag are captured in an output register that feeds the next pipeline stage. The surrounding control samples the flag and decides whether to take an overflow trap.

The register is cleared by an asynchronous active-low reset. Release of that reset is synchronised to the clock through two stages.

Top module: `int_alu_ex`

## Requirements
- R1: With use_imm low, op_sel 0 (add) yields src_a+src_b modulo 2^32, and 1 (add, non-trapping) yields the same sum. op_sel 2 (subtract) yields src_a-src_b modulo 2^32, and 3 (subtract, non-trapping) yields the same difference.
- R2: For op_sel 0 and 2, ovf_flag is 1 exactly when the true signed sum or difference of the two operands lies outside -2^31..2^31-1.
- R3: ovf_flag is 0 for every op_sel other than 0 and 2, including the non-trapping codes 1 and 3.
- R4: op_sel 4, 5 and 6 give the bitwise AND, OR and XOR of src_a and the second operand.
- R5: op_sel 7 (left logical), 8 (right logical) and 9 (right arithmetic, sign filled) shift src_a by the low 5 bits of the second operand. The upper bits of the second operand have no effect.
- R6: op_sel 10 yields imm_in in bits 31..16 and zeros in bits 15..0, whatever src_a holds.
- R7: op_sel 11..16 compare src_a with the second operand as signed values, in the order less-than, greater-than, less-or-equal, greater-or-equal, equal, not-equal. The result is exactly 1 when the condition holds and 0 otherwise.
- R8: op_sel 17 yields src_a plus sign-extended imm_in, whatever use_imm and src_b hold, and never sets ovf_flag.
- R9: With use_imm high, the second operand is imm_in sign-extended from bit 15 instead of src_b.
- R10: result and ovf_flag are zero while reset is held, and reflect the inputs of the previous clock edge once it is released. An op_sel of 18..31 yields result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Register second operand |
| imm_in | input | 16 | Immediate, sign-extended inside the block |
| use_imm | input | 1 | Selects the immediate as second operand |
| result | output | 32 | Registered result |
| ovf_flag | output | 1 | Registered signed-overflow flag |

## Verification
Two functions can fall in the same cycle:
- a set-compare whose operands would overflow if subtracted;
- a signed subtract that overflows on the same operand pair.

The bench applies the pair (most negative value, 1) and the pair (most positive value, most negative value) to both the compare codes and the subtract code. It checks that the compare still returns the true signed order while the subtract raises the flag.

A reference model works on 64-bit signed integers and judges every cycle. It predicts overflow from range rather than from sign bits. It also checks that an effective-address sum crossing the signed range leaves the flag low.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_SLL  = 5'd7,
    OP_SRL  = 5'd8,
    OP_SRA  = 5'd9,
    OP_LHI  = 5'd10,
    OP_SLT  = 5'd11,
    OP_SGT  = 5'd12,
    OP_SLE  = 5'd13,
    OP_SGE  = 5'd14,
    OP_SEQ  = 5'd15,
    OP_SNE  = 5'd16,
    OP_EA   = 5'd17
  } alu_op_e;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              pick_imm,
  output logic [DATA_W-1:0] imm_sx,
  output logic [DATA_W-1:0] opnd2
);
  localparam int EXT_W = DATA_W - IMM_W;

  always_comb begin
    imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    opnd2  = pick_imm ? imm_sx : reg_b;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_s
);
  logic [DATA_W-1:0] y_eff;

  always_comb begin
    y_eff = do_sub ? ~y : y;
    sum   = x + y_eff + {{(DATA_W-1){1'b0}}, do_sub};
    // Same-sign inputs giving an opposite-sign sum means signed overflow.
    ovf_s = (x[DATA_W-1] == y_eff[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               go_left,
  input  logic               arith,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] stg [SHAMT_W+1];
  logic              fill;

  // A left shift is a right shift of the bit-reversed word.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_in[i] = din[DATA_W-1-i];
    fill   = arith & ~go_left & din[DATA_W-1];
    stg[0] = go_left ? rev_in : din;
  end

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    always_comb begin
      if (amt[s]) stg[s+1] = {{DIST{fill}}, stg[s][DATA_W-1:DIST]};
      else        stg[s+1] = stg[s];
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      dout[i] = go_left ? stg[SHAMT_W][DATA_W-1-i] : stg[SHAMT_W][i];
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic [2:0]        cond_sel,
  output logic              hit
);
  logic lt, eq;

  always_comb begin
    // Direct signed comparison: immune to subtract overflow.
    lt = $signed(x) < $signed(y);
    eq = (x == y);
    unique case (cond_sel)
      3'd0:    hit = lt;
      3'd1:    hit = ~lt & ~eq;
      3'd2:    hit = lt | eq;
      3'd3:    hit = ~lt;
      3'd4:    hit = eq;
      3'd5:    hit = ~eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_alu_ex.sv
module int_alu_ex
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_in,
  input  logic              use_imm,
  output logic [DATA_W-1:0] result,
  output logic              ovf_flag
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int LOW_W   = DATA_W - IMM_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [DATA_W-1:0] imm_sx, opnd2, add_y, add_sum, sh_out;
  logic              add_sub, add_ovf, sh_left, sh_arith, cmp_hit;
  logic [2:0]        cmp_sel;
  logic [DATA_W-1:0] res_d, res_q;
  logic              ovf_d, ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .reg_b(src_b), .imm(imm_in), .pick_imm(use_imm),
    .imm_sx(imm_sx), .opnd2(opnd2)
  );

  always_comb begin
    add_sub  = (op_sel == OP_SUB) || (op_sel == OP_SUBU);
    add_y    = (op_sel == OP_EA) ? imm_sx : opnd2;
    sh_left  = (op_sel == OP_SLL);
    sh_arith = (op_sel == OP_SRA);
    cmp_sel  = 3'(op_sel - OP_SLT);
  end

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .x(src_a), .y(add_y), .do_sub(add_sub), .sum(add_sum), .ovf_s(add_ovf)
  );

  alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .din(src_a), .amt(opnd2[SHAMT_W-1:0]), .go_left(sh_left),
    .arith(sh_arith), .dout(sh_out)
  );

  alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .x(src_a), .y(opnd2), .cond_sel(cmp_sel), .hit(cmp_hit)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        res_d = add_sum;
        ovf_d = add_ovf;
      end
      OP_ADDU, OP_SUBU, OP_EA: res_d = add_sum;
      OP_AND: res_d = src_a & opnd2;
      OP_OR:  res_d = src_a | opnd2;
      OP_XOR: res_d = src_a ^ opnd2;
      OP_SLL, OP_SRL, OP_SRA: res_d = sh_out;
      OP_LHI: res_d = {imm_in, {LOW_W{1'b0}}};
      OP_SLT, OP_SGT, OP_SLE, OP_SGE, OP_SEQ, OP_SNE:
        res_d = {{(DATA_W-1){1'b0}}, cmp_hit};
      default: begin
        res_d = '0;
        ovf_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign result   = res_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/alu_chk.sv
module alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [IMM_W-1:0]  imm,
  input logic              sel_imm,
  input logic [DATA_W-1:0] res,
  input logic              ovf
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] sx, o2;
  assign sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign o2 = sel_imm ? sx : b;

  assert_addu_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_ADDU) |-> (res == $past(a) + $past(o2)));

  assert_ovf_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_ADD) |->
      (ovf == (($past(a[DATA_W-1]) == $past(o2[DATA_W-1])) &&
               (res[DATA_W-1] != $past(a[DATA_W-1])))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) != OP_ADD && $past(op) != OP_SUB) |-> !ovf);

  assert_lhi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_LHI) |->
      (res == {$past(imm), {EXT_W{1'b0}}}));

  assert_cmp_bool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) >= OP_SLT && $past(op) <= OP_SNE) |->
      (res[DATA_W-1:1] == '0));

  assert_ea_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_EA) |-> (res == $past(a) + $past(sx)));

  assert_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) > OP_EA) |-> (res == '0));
endmodule

bind int_alu_ex alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op(op_sel), .a(src_a), .b(src_b),
  .imm(imm_in), .sel_imm(use_imm), .res(result), .ovf(ovf_flag)
);

// File: tb/sim_int_alu_ex.sv
module sim_int_alu_ex;
  logic        clk;
  logic        rst_n;
  logic [4:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm_in;
  logic        use_imm;
  logic [31:0] result;
  logic        ovf_flag;

  int n_chk  = 0;
  int n_fail = 0;

  int_alu_ex u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .imm_in(imm_in), .use_imm(use_imm), .result(result), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string tag_of(int op, bit sel);
    if (op > 17)               return "R10";
    if (op == 17)              return "R8";
    if (sel && op <= 6)        return "R9";
    if (op <= 3)               return "R1/R2/R3";
    if (op <= 6)               return "R4";
    if (op <= 9)               return "R5";
    if (op == 10)              return "R6";
    return "R7";
  endfunction

  // Behavioural reference: 64-bit signed arithmetic, range-based overflow.
  function automatic logic [32:0] ref_model(int op, logic [31:0] a, logic [31:0] b,
                                            logic [15:0] im, bit sel);
    logic [31:0] sx, o2, r;
    longint      sa, so, full;
    bit          ov;
    sx = {{16{im[15]}}, im};
    o2 = sel ? sx : b;
    sa = longint'($signed(a));
    so = longint'($signed(o2));
    r  = 32'h0;
    ov = 1'b0;
    case (op)
      0, 1: begin
        full = sa + so;
        r = full[31:0];
        ov = (op == 0) && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      2, 3: begin
        full = sa - so;
        r = full[31:0];
        ov = (op == 2) && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      4:  r = a & o2;
      5:  r = a | o2;
      6:  r = a ^ o2;
      7:  r = a << o2[4:0];
      8:  r = a >> o2[4:0];
      9:  r = $signed(a) >>> o2[4:0];
      10: r = {im, 16'h0};
      11: r = {31'h0, sa <  so};
      12: r = {31'h0, sa >  so};
      13: r = {31'h0, sa <= so};
      14: r = {31'h0, sa >= so};
      15: r = {31'h0, sa == so};
      16: r = {31'h0, sa != so};
      17: begin full = sa + longint'($signed(sx)); r = full[31:0]; end
      default: r = 32'h0;
    endcase
    return {ov, r};
  endfunction

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual ovf=%0b res=%08h expected ovf=%0b res=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // Drive at a falling edge; the result is registered at the next rising
  // edge and sampled at the falling edge after it.
  task automatic step(int op, logic [31:0] a, logic [31:0] b, logic [15:0] im, bit sel);
    logic [32:0] exp;
    op_sel = 5'(op); src_a = a; src_b = b; imm_in = im; use_imm = sel;
    exp = ref_model(op, a, b, im, sel);
    @(negedge clk);
    check(tag_of(op, sel), {ovf_flag, result}, exp);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_sel = 5'd0; src_a = 32'h1234_5678; src_b = 32'h1111_1111;
    imm_in = 16'h0; use_imm = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 reset", {ovf_flag, result}, 33'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2/R3: add and subtract at the signed boundaries
    step(0, 32'h7fffffff, 32'h1,        16'h0, 0);
    step(0, 32'h80000000, 32'hffffffff, 16'h0, 0);
    step(0, 32'h5,        32'hfffffffd, 16'h0, 0);
    step(1, 32'h7fffffff, 32'h1,        16'h0, 0);
    step(2, 32'h80000000, 32'h1,        16'h0, 0);
    step(2, 32'h0,        32'h80000000, 16'h0, 0);
    step(2, 32'hffffffff, 32'h80000000, 16'h0, 0);
    step(3, 32'h0,        32'h80000000, 16'h0, 0);
    // R9: immediate as second operand
    step(0, 32'd10,       32'hdeadbeef, 16'hffff, 1);
    step(0, 32'h80000000, 32'h0,        16'h8000, 1);
    step(5, 32'h0000f000, 32'hffffffff, 16'h00ff, 1);
    // R4
    step(4, 32'hf0f0f0f0, 32'h0ff00ff0, 16'h0, 0);
    step(5, 32'hf0f0f0f0, 32'h0ff00ff0, 16'h0, 0);
    step(6, 32'hf0f0f0f0, 32'h0ff00ff0, 16'h0, 0);
    // R5: shift amount from low five bits only
    step(7, 32'h00000003, 32'hffffffe3, 16'h0, 0);
    step(8, 32'h80000000, 32'd31,       16'h0, 0);
    step(9, 32'h80000000, 32'd4,        16'h0, 0);
    step(9, 32'h40000000, 32'd4,        16'h0, 0);
    step(7, 32'h12345678, 32'h20,       16'h0, 0);
    // R6: upper-half immediate ignores src_a
    step(10, 32'hffffffff, 32'h0, 16'habcd, 0);
    // R7: compares where a subtract would overflow, plus equality
    step(11, 32'h80000000, 32'h1, 16'h0, 0);
    step(12, 32'h80000000, 32'h1, 16'h0, 0);
    step(12, 32'h7fffffff, 32'h80000000, 16'h0, 0);
    step(2,  32'h7fffffff, 32'h80000000, 16'h0, 0);
    for (int c = 11; c <= 16; c++) step(c, 32'h5, 32'h5, 16'h0, 0);
    // R8: address sum ignores use_imm and src_b, never flags
    step(17, 32'h1000,     32'hffffffff, 16'hfffc, 0);
    step(17, 32'h7fffffff, 32'h0,        16'h0001, 1);
    // R10: unused codes
    step(20, 32'h7fffffff, 32'h1, 16'h0, 0);
    step(31, 32'hffffffff, 32'hffffffff, 16'hffff, 1);

    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 19)), $urandom, $urandom,
           16'($urandom), bit'($urandom_range(0, 1)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule